// File: doc/BRIEF.md
# Four-Source Interrupt Controller

This block gathers four interrupt sources and drives one interrupt request to the processor core. The sources are an external pin with a selectable edge, a timer overflow pulse, a change on four monitored port pins, and a pulse that marks the end of a data EEPROM write. For each source it keeps a pending flag and an enable bit. A global enable gates the request.

The processor reaches the flags and enables through two 8-bit register views, chosen by a select line. When the core takes an interrupt, it pulses `int_ack`. The block then clears the global enable and presents a one-cycle vector load with the fixed service address. A return-from-interrupt pulse sets the global enable again. A separate wake-up output lets a sleeping core resume on any enabled pending source, whatever the state of the global enable.

All interfaces are plain control and status pins. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure. Source bit order is fixed: bit 0 external pin, bit 1 timer, bit 2 port change, bit 3 EEPROM done.

Top module: `irq_hub`

## Requirements
- R1: After reset the global enable, all enables and all flags are 0, and `irq`, `wake` and `vec_load` are low.
- R2: A source event sets its flag on the next clock edge whatever the state of its enable bit and of the global enable.
- R3: `irq` is high exactly when the global enable is 1 and at least one source has both its flag and its enable set.
- R4: `wake` is high when at least one source has both its flag and its enable set, even while the global enable is 0.
- R5: A pulse on `int_ack` clears the global enable on the next edge. On that same edge `vec_load` rises for one cycle with `vec_addr` equal to 0x0004.
- R6: A pulse on `ret_intr` sets the global enable. A flag still pending and enabled raises `irq` in the very cycle the global enable becomes 1.
- R7: Flags are sticky and change only through a write to the flag view. A write of 0 never wins over an event that arrives in the same cycle.
- R8: The external pin passes through a `SYNC_STAGES`-flop synchroniser. Its flag is set on the edge chosen by `ext_rise` (1 = rising, 0 = falling), one clock after the synchronised value shows that edge. The opposite edge sets nothing.
- R9: The port-change flag is set on every cycle in which the synchronised `port_pins` differ from the copy captured on the last `port_rd` pulse.
- R10: Register map. With `reg_sel`=0 the view holds the global enable at bit 7 and the enables at bits 3:0, and bits 6:4 read 0. With `reg_sel`=1 the view holds the flags at bits 3:0, and bits 7:4 read 0.
- R11: The global enable follows this priority in one cycle: `int_ack` clears it over `ret_intr`, and `ret_intr` sets it over a software write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pin | input | 1 | External interrupt pin, asynchronous |
| ext_rise | input | 1 | Edge select for the external pin: 1 rising, 0 falling |
| tmr_ovf | input | 1 | Timer overflow pulse |
| ee_done | input | 1 | EEPROM write-complete pulse |
| port_pins | input | 4 | Monitored port pins, asynchronous |
| port_rd | input | 1 | Port read strobe, captures the compare copy |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | View select: 0 enables, 1 flags |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for the selected view |
| int_ack | input | 1 | Core accepts the interrupt |
| ret_intr | input | 1 | Return-from-interrupt executes |
| irq | output | 1 | Interrupt request to the core |
| wake | output | 1 | Wake-up request from sleep |
| vec_load | output | 1 | One-cycle program-counter load strobe |
| vec_addr | output | 13 | Service vector address |

## Verification
The bench builds the block with its default parameters: two synchroniser stages, a 13-bit vector and service address 0x0004. With two stages, the pin-to-flag latency is three clock edges. The bench therefore checks that the flag is still clear after two edges and set after the third, for both edge polarities and for the port comparator. The default vector lets the acknowledge scenario compare `vec_addr` against the fixed 0x0004 during the load strobe.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC     = 4;
  localparam int REG_W    = 8;
  localparam int GEN_BIT  = 7;
  localparam int SRC_EXT  = 0;
  localparam int SRC_TMR  = 1;
  localparam int SRC_PORT = 2;
  localparam int SRC_EE   = 3;
  typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/ext_edge.sv
module ext_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic rise_sel,
  output logic hit
);
  logic s_q, prev_q;

  sync_chain #(.W(1), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin), .q(s_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= s_q;
  end

  assign hit = rise_sel ? (s_q & ~prev_q) : (~s_q & prev_q);
endmodule

// File: rtl/port_watch.sv
module port_watch #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins,
  input  logic         rd,
  output logic         hit
);
  logic [W-1:0] s_q, copy_q;

  sync_chain #(.W(W), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins), .q(s_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)  copy_q <= '0;
    else if (rd) copy_q <= s_q;
  end

  assign hit = |(s_q ^ copy_q);
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  src_vec_t         ev,
  input  logic             we,
  input  logic             sel,
  input  logic [REG_W-1:0] wdata,
  input  logic             ack,
  input  logic             ret,
  output logic             gen,
  output src_vec_t         en,
  output src_vec_t         flags
);
  logic wr_ctl, wr_flg;
  logic unused_wbits;

  assign wr_ctl = we & ~sel;
  assign wr_flg = we & sel;
  assign unused_wbits = ^wdata[GEN_BIT-1:NSRC];

  // priority: acknowledge, then return, then software write
  always_ff @(posedge clk) begin
    if (!rst_n)      gen <= 1'b0;
    else if (ack)    gen <= 1'b0;
    else if (ret)    gen <= 1'b1;
    else if (wr_ctl) gen <= wdata[GEN_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      en <= '0;
    else if (wr_ctl) en <= wdata[NSRC-1:0];
  end

  // events set flags unconditionally and win against a clearing write
  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= (wr_flg ? wdata[NSRC-1:0] : flags) | ev;
  end

  p_ack_clears_gen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !gen);

  p_ret_sets_gen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && !ack) |=> gen);

  p_event_sets_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != '0) |=> ((flags & $past(ev)) == $past(ev)));

  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_flg |=> ((flags & $past(flags)) == $past(flags)));
endmodule

// File: rtl/irq_hub.sv
module irq_hub #(
  parameter int          SYNC_STAGES = 2,
  parameter int          PORT_W      = 4,
  parameter int          PC_W        = 13,
  parameter logic [12:0] VEC_ADDR    = 13'h0004
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ext_pin,
  input  logic        ext_rise,
  input  logic        tmr_ovf,
  input  logic        ee_done,
  input  logic [3:0]  port_pins,
  input  logic        port_rd,
  input  logic        reg_we,
  input  logic        reg_sel,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic        int_ack,
  input  logic        ret_intr,
  output logic        irq,
  output logic        wake,
  output logic        vec_load,
  output logic [12:0] vec_addr
);
  import irq_pkg::*;

  localparam int PAD_CTL = GEN_BIT - NSRC;
  localparam int PAD_FLG = REG_W - NSRC;

  logic     ext_hit, port_hit, gen;
  src_vec_t ev, en, flags, pending;
  logic [PORT_W-1:0] pins_w;

  assign pins_w = port_pins[PORT_W-1:0];

  ext_edge #(.STAGES(SYNC_STAGES)) u_ext (
    .clk(clk), .rst_n(rst_n), .pin(ext_pin), .rise_sel(ext_rise), .hit(ext_hit)
  );

  port_watch #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_port (
    .clk(clk), .rst_n(rst_n), .pins(pins_w), .rd(port_rd), .hit(port_hit)
  );

  always_comb begin
    ev           = '0;
    ev[SRC_EXT]  = ext_hit;
    ev[SRC_TMR]  = tmr_ovf;
    ev[SRC_PORT] = port_hit;
    ev[SRC_EE]   = ee_done;
  end

  irq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .ev(ev), .we(reg_we), .sel(reg_sel),
    .wdata(reg_wdata), .ack(int_ack), .ret(ret_intr),
    .gen(gen), .en(en), .flags(flags)
  );

  assign pending = flags & en;
  assign wake    = |pending;
  assign irq     = gen & wake;

  assign reg_rdata = reg_sel ? {{PAD_FLG{1'b0}}, flags}
                             : {gen, {PAD_CTL{1'b0}}, en};

  always_ff @(posedge clk) begin
    if (!rst_n) vec_load <= 1'b0;
    else        vec_load <= int_ack;
  end

  assign vec_addr = VEC_ADDR[PC_W-1:0];

  p_vec_on_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack |=> (vec_load && vec_addr == 13'h0004));
endmodule

// File: tb/irq_hub_tb.sv
module irq_hub_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC       = 2;
  localparam int LAT        = SYNC + 1;

  logic clk = 0, rst_n = 0;
  logic ext_pin = 0, ext_rise = 1, tmr_ovf = 0, ee_done = 0;
  logic [3:0] port_pins = 0;
  logic port_rd = 0, reg_we = 0, reg_sel = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic int_ack = 0, ret_intr = 0;
  logic irq, wake, vec_load;
  logic [12:0] vec_addr;
  int nchk = 0, nerr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_hub u_dut (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .ext_rise(ext_rise),
    .tmr_ovf(tmr_ovf), .ee_done(ee_done), .port_pins(port_pins),
    .port_rd(port_rd), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .int_ack(int_ack),
    .ret_intr(ret_intr), .irq(irq), .wake(wake), .vec_load(vec_load),
    .vec_addr(vec_addr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    reg_we = 1; reg_sel = sel; reg_wdata = d;
    tick();
    reg_we = 0;
  endtask

  task automatic rd_view(input logic sel, output logic [7:0] d);
    reg_sel = sel; #1; d = reg_rdata;
  endtask

  task automatic clear_all();
    wr(0, 8'h00); wr(1, 8'h00);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd_view(0, v); chk("R1 ctl view", v, 8'h00);
    rd_view(1, v); chk("R1 flag view", v, 8'h00);
    chk("R1 irq", irq, 0); chk("R1 wake", wake, 0); chk("R1 vec_load", vec_load, 0);
  endtask

  task automatic t_masked_flags();
    logic [7:0] v;
    tmr_ovf = 1; ee_done = 1; tick(); tmr_ovf = 0; ee_done = 0;
    rd_view(1, v); chk("R2 flags set while masked", v, 8'h0A);
    chk("R2 no irq while masked", irq, 0);
    chk("R4 no wake while disabled", wake, 0);
    clear_all();
  endtask

  task automatic t_gate_and_wake();
    tmr_ovf = 1; tick(); tmr_ovf = 0;
    wr(0, 8'h02);
    chk("R4 wake with gen=0", wake, 1);
    chk("R3 irq blocked gen=0", irq, 0);
    wr(0, 8'h82);
    chk("R3 irq with gen=1", irq, 1);
    wr(0, 8'h84);
    chk("R3 irq off when source disabled", irq, 0);
    chk("R4 wake off when source disabled", wake, 0);
    clear_all();
  endtask

  task automatic t_ack_ret();
    logic [7:0] v;
    wr(0, 8'h88); ee_done = 1; tick(); ee_done = 0;
    chk("R3 irq pending", irq, 1);
    int_ack = 1; tick(); int_ack = 0;
    rd_view(0, v); chk("R5 gen cleared", v[7], 0);
    chk("R5 vec_load", vec_load, 1); chk("R5 vec_addr", vec_addr, 13'h0004);
    chk("R5 irq dropped", irq, 0); chk("R4 wake stays", wake, 1);
    tick(); chk("R5 vec_load one cycle", vec_load, 0);
    ret_intr = 1; tick(); ret_intr = 0;
    chk("R6 irq again at once", irq, 1);
    rd_view(0, v); chk("R6 gen set", v[7], 1);
    clear_all();
  endtask

  task automatic t_collision();
    logic [7:0] v;
    tmr_ovf = 1; ee_done = 1; tick(); tmr_ovf = 0; ee_done = 0;
    tick(3);
    rd_view(1, v); chk("R7 flags sticky", v, 8'h0A);
    reg_we = 1; reg_sel = 1; reg_wdata = 8'h00; tmr_ovf = 1;
    tick(); reg_we = 0; tmr_ovf = 0;
    rd_view(1, v); chk("R7 event beats clear", v, 8'h02);
    clear_all();
  endtask

  task automatic t_ext_edge();
    logic [7:0] v;
    ext_rise = 1; ext_pin = 1;
    tick(LAT - 1); rd_view(1, v); chk("R8 rise not yet", v[0], 0);
    tick(); rd_view(1, v); chk("R8 rise flag", v[0], 1);
    wr(1, 8'h00);
    ext_pin = 0; tick(LAT + 2);
    rd_view(1, v); chk("R8 falling ignored in rise mode", v[0], 0);
    ext_rise = 0; ext_pin = 1; tick(LAT + 2);
    rd_view(1, v); chk("R8 rising ignored in fall mode", v[0], 0);
    ext_pin = 0;
    tick(LAT - 1); rd_view(1, v); chk("R8 fall not yet", v[0], 0);
    tick(); rd_view(1, v); chk("R8 fall flag", v[0], 1);
    ext_rise = 1; clear_all();
  endtask

  task automatic t_port();
    logic [7:0] v;
    port_pins = 4'b0100;
    tick(LAT - 1); rd_view(1, v); chk("R9 not yet", v[2], 0);
    tick(); rd_view(1, v); chk("R9 change flag", v[2], 1);
    wr(1, 8'h00); rd_view(1, v); chk("R9 re-set while mismatch", v[2], 1);
    port_rd = 1; tick(); port_rd = 0;
    wr(1, 8'h00); tick(2);
    rd_view(1, v); chk("R9 clear after read", v[2], 0);
  endtask

  task automatic t_regmap();
    logic [7:0] v;
    wr(0, 8'hFF); rd_view(0, v); chk("R10 ctl view pads", v, 8'h8F);
    wr(1, 8'hFF); rd_view(1, v); chk("R10 flag view pads", v, 8'h0F);
    clear_all();
  endtask

  task automatic t_priority();
    logic [7:0] v;
    wr(0, 8'h80);
    int_ack = 1; ret_intr = 1; tick(); int_ack = 0; ret_intr = 0;
    rd_view(0, v); chk("R11 ack over ret", v[7], 0);
    ret_intr = 1; reg_we = 1; reg_sel = 0; reg_wdata = 8'h00;
    tick(); ret_intr = 0; reg_we = 0;
    rd_view(0, v); chk("R11 ret over write", v[7], 1);
    clear_all();
  endtask

  initial begin
    tick(3); rst_n = 1; tick();
    t_reset();
    t_masked_flags();
    t_gate_and_wake();
    t_ack_ret();
    t_collision();
    t_ext_edge();
    t_port();
    t_regmap();
    t_priority();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    nchk++; nerr++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule